// File: doc/BRIEF.md
# Wake-on-LAN Magic Packet Detector

The block watches the byte stream of received Ethernet frames and raises a wake event when a frame carries a magic packet for the local station. A magic packet is a synchronisation run of FFh bytes followed at once by the station's 48-bit address repeated back to back. The run may start anywhere after the two address fields at the head of the frame. Bytes arrive one per cycle when `rx_valid` is high. `rx_sof` marks the first byte of a frame and `rx_eof` marks the last. `rx_good` is sampled with the last byte and tells whether the frame passed its integrity check.

Whether the search is armed depends on the power state code and the enable input. A complete pattern leads to a wake event only when the frame ends good. The event is given as a one-cycle pulse and as a sticky flag that stays set until software clears it.

Top module: `wol_magic_detect`

## Requirements
- R1: After reset, `wake_pulse` and `wake_status` are both low.
- R2: The pattern is SYNC_LEN (default 6) bytes of FFh followed immediately by NUM_REPS (default 16) copies of `station_mac`. Within each copy, the first byte compared is bits 47:40 and the last is bits 7:0. Any other byte order does not match.
- R3: The first HDR_BYTES (default 12) bytes of a frame, counted from the byte flagged by `rx_sof`, are never examined. A pattern that starts at byte HDR_BYTES is detected.
- R4: With `pwr_state` = 2'b00 (full power), a frame is acted upon only when `mp_enable` is high at its last byte.
- R5: With `pwr_state` = 2'b01 (light sleep), a frame is acted upon whatever the value of `mp_enable`.
- R6: With `pwr_state` = 2'b10 or 2'b11, no wake event is ever produced.
- R7: A sync run longer than SYNC_LEN bytes still leads to detection; the latest SYNC_LEN FFh bytes count as the sync.
- R8: A byte that mismatches during the address copies abandons the attempt. If that byte is FFh, it counts as the first byte of a new sync run.
- R9: `wake_pulse` is high for exactly the one cycle after the clock edge that takes in the last byte. It rises only if `rx_good` is high with that byte, the search is armed, and the full pattern has been seen in that frame.
- R10: `wake_status` is set with every wake pulse and stays set until `status_clr` is high. Setting takes priority over a clear in the same cycle.
- R11: A frame with an incomplete pattern (a short sync run, fewer than NUM_REPS copies, or a corrupted address byte) produces no wake event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive byte qualifier |
| rx_sof | input | 1 | First byte of frame, qualified by rx_valid |
| rx_eof | input | 1 | Last byte of frame, qualified by rx_valid |
| rx_data | input | 8 | Receive byte |
| rx_good | input | 1 | Frame passed integrity check, sampled with the last byte |
| station_mac | input | 48 | Local station address, bits 47:40 sent first |
| mp_enable | input | 1 | Magic packet enable for the full-power state |
| pwr_state | input | 2 | 00 full power, 01 light sleep, 10/11 disabled |
| status_clr | input | 1 | Clears the sticky wake flag |
| wake_pulse | output | 1 | One-cycle wake event |
| wake_status | output | 1 | Sticky wake flag |

## Verification
The bench builds the detector with NUM_REPS = 3 and keeps SYNC_LEN = 6 and HDR_BYTES = 12. The short copy count makes each frame small. That in turn allows a full sweep in which every single address position is corrupted in turn. It also allows every combination of power code, enable and good flag to be tried. Sync runs from five to ten bytes, patterns placed at the header boundary, and mismatching bytes that do or do not restart a sync run are each driven and checked against expectations computed in the bench.

// File: rtl/wol_pkg.sv
package wol_pkg;
  localparam int MAC_OCTETS = 6;

  typedef enum logic [1:0] {
    PWR_FULL  = 2'b00,
    PWR_LIGHT = 2'b01,
    PWR_DEEP  = 2'b10,
    PWR_OFF   = 2'b11
  } pwr_e;
endpackage

// File: rtl/wol_arm.sv
module wol_arm
  import wol_pkg::*;
(
  input  logic [1:0] pwr_state,
  input  logic       mp_enable,
  output logic       armed
);
  pwr_e pwr;
  assign pwr = pwr_e'(pwr_state);

  always_comb begin
    unique case (pwr)
      PWR_FULL:  armed = mp_enable;
      PWR_LIGHT: armed = 1'b1;
      default:   armed = 1'b0;
    endcase
  end
endmodule

// File: rtl/wol_hdr_skip.sv
module wol_hdr_skip #(
  parameter int HDR_BYTES = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_valid,
  input  logic rx_sof,
  output logic in_payload
);
  localparam int CW = $clog2(HDR_BYTES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HDR_BYTES);

  logic [CW-1:0] seen;
  logic [CW-1:0] pos;

  assign pos        = rx_sof ? '0 : seen;
  assign in_payload = rx_valid && (pos >= LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= LIMIT;
    end else if (rx_valid) begin
      seen <= (pos == LIMIT) ? LIMIT : pos + 1'b1;
    end
  end

  assert_hdr_bound_R3: assert property (@(posedge clk) disable iff (rst)
    seen <= LIMIT);
endmodule

// File: rtl/wol_matcher.sv
module wol_matcher
  import wol_pkg::*;
#(
  parameter int SYNC_LEN = 6,
  parameter int NUM_REPS = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        restart,
  input  logic        byte_vld,
  input  logic [7:0]  byte_in,
  input  logic [47:0] mac,
  output logic        found,
  output logic        hit_now
);
  localparam int SW = $clog2(SYNC_LEN + 1);
  localparam int OW = $clog2(MAC_OCTETS);
  localparam int RW = (NUM_REPS > 1) ? $clog2(NUM_REPS) : 1;
  localparam logic [SW-1:0] SYNC_FULL = SW'(SYNC_LEN);
  localparam logic [OW-1:0] OCT_LAST  = OW'(MAC_OCTETS - 1);
  localparam logic [RW-1:0] REP_LAST  = RW'(NUM_REPS - 1);

  logic [7:0] mac_oct [MAC_OCTETS];
  for (genvar k = 0; k < MAC_OCTETS; k++) begin : g_oct
    assign mac_oct[k] = mac[(MAC_OCTETS-k)*8-1 -: 8];
  end

  logic [SW-1:0] sync_cnt, sync_nx;
  logic          in_addr, in_addr_nx;
  logic [OW-1:0] oct_idx, oct_nx;
  logic [RW-1:0] rep_idx, rep_nx;
  logic          found_nx;

  logic is_ff, oct_hit;
  assign is_ff   = (byte_in == 8'hFF);
  assign oct_hit = (byte_in == mac_oct[oct_idx]);
  assign hit_now = byte_vld && in_addr && oct_hit &&
                   (oct_idx == OCT_LAST) && (rep_idx == REP_LAST);

  always_comb begin
    sync_nx    = sync_cnt;
    in_addr_nx = in_addr;
    oct_nx     = oct_idx;
    rep_nx     = rep_idx;
    found_nx   = found;
    if (restart) begin
      sync_nx    = '0;
      in_addr_nx = 1'b0;
      oct_nx     = '0;
      rep_nx     = '0;
      found_nx   = 1'b0;
    end else if (byte_vld) begin
      if (in_addr) begin
        if (oct_hit) begin
          if (oct_idx == OCT_LAST) begin
            oct_nx = '0;
            if (rep_idx == REP_LAST) begin
              found_nx   = 1'b1;
              in_addr_nx = 1'b0;
              rep_nx     = '0;
              sync_nx    = '0;
            end else begin
              rep_nx = rep_idx + 1'b1;
            end
          end else begin
            oct_nx = oct_idx + 1'b1;
          end
        end else begin
          in_addr_nx = 1'b0;
          oct_nx     = '0;
          rep_nx     = '0;
          sync_nx    = is_ff ? SW'(1) : '0;
        end
      end else if ((sync_cnt == SYNC_FULL) && oct_hit) begin
        in_addr_nx = 1'b1;
        oct_nx     = OW'(1);
        rep_nx     = '0;
        sync_nx    = '0;
      end else if (is_ff) begin
        sync_nx = (sync_cnt == SYNC_FULL) ? SYNC_FULL : sync_cnt + 1'b1;
      end else begin
        sync_nx = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_cnt <= '0;
      in_addr  <= 1'b0;
      oct_idx  <= '0;
      rep_idx  <= '0;
      found    <= 1'b0;
    end else begin
      sync_cnt <= sync_nx;
      in_addr  <= in_addr_nx;
      oct_idx  <= oct_nx;
      rep_idx  <= rep_nx;
      found    <= found_nx;
    end
  end

  assert_sync_bound_R7: assert property (@(posedge clk) disable iff (rst)
    sync_cnt <= SYNC_FULL);
  assert_rep_bound_R2: assert property (@(posedge clk) disable iff (rst)
    rep_idx <= REP_LAST);
  assert_addr_entry_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(in_addr) |-> ($past(sync_cnt) == SYNC_FULL));
  assert_found_entry_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(found) |-> $past(in_addr));
endmodule

// File: rtl/wol_magic_detect.sv
module wol_magic_detect
  import wol_pkg::*;
#(
  parameter int SYNC_LEN  = 6,
  parameter int NUM_REPS  = 16,
  parameter int HDR_BYTES = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic [7:0]  rx_data,
  input  logic        rx_good,
  input  logic [47:0] station_mac,
  input  logic        mp_enable,
  input  logic [1:0]  pwr_state,
  input  logic        status_clr,
  output logic        wake_pulse,
  output logic        wake_status
);
  logic armed, in_payload, found, hit_now, seen_all, wake_now;

  wol_arm u_arm (
    .pwr_state (pwr_state),
    .mp_enable (mp_enable),
    .armed     (armed)
  );

  wol_hdr_skip #(.HDR_BYTES(HDR_BYTES)) u_hdr (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .rx_sof     (rx_sof),
    .in_payload (in_payload)
  );

  wol_matcher #(.SYNC_LEN(SYNC_LEN), .NUM_REPS(NUM_REPS)) u_match (
    .clk      (clk),
    .rst      (rst),
    .restart  (rx_valid && rx_sof),
    .byte_vld (in_payload),
    .byte_in  (rx_data),
    .mac      (station_mac),
    .found    (found),
    .hit_now  (hit_now)
  );

  assign seen_all = (found && !rx_sof) || hit_now;
  assign wake_now = rx_valid && rx_eof && rx_good && armed && seen_all;

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_pulse  <= 1'b0;
      wake_status <= 1'b0;
    end else begin
      wake_pulse <= wake_now;
      if (wake_now)        wake_status <= 1'b1;
      else if (status_clr) wake_status <= 1'b0;
    end
  end

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse);
  assert_pulse_at_end_R9: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> $past(rx_valid && rx_eof && rx_good));
  assert_pulse_power_R6: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> !$past(pwr_state[1]));
  assert_full_needs_en_R4: assert property (@(posedge clk) disable iff (rst)
    (wake_pulse && ($past(pwr_state) == 2'b00)) |-> $past(mp_enable));
  assert_status_clear_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(wake_status) |-> $past(status_clr));
  assert_status_set_R10: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> wake_status);
endmodule

// File: tb/test_wol_magic_detect.sv
module test_wol_magic_detect;
  localparam int REPS = 3;
  localparam int HDR  = 12;
  localparam logic [47:0] MAC = 48'h02A1B2C3D4E5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_good = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic mp_enable = 1'b0, status_clr = 1'b0;
  logic [1:0] pwr_state = 2'b00;
  logic wake_pulse, wake_status;

  always #10 clk = ~clk;

  wol_magic_detect #(.SYNC_LEN(6), .NUM_REPS(REPS), .HDR_BYTES(HDR)) i_wol_magic_detect (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_data(rx_data), .rx_good(rx_good), .station_mac(MAC),
    .mp_enable(mp_enable), .pwr_state(pwr_state), .status_clr(status_clr),
    .wake_pulse(wake_pulse), .wake_status(wake_status)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] fbuf [0:255];
  int flen;

  task automatic chk(input logic act, input logic exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] oct(input int k);
    return MAC[47-8*k -: 8];
  endfunction

  task automatic put(input logic [7:0] b);
    fbuf[flen] = b;
    flen++;
  endtask

  task automatic head();
    flen = 0;
    for (int i = 0; i < HDR; i++) put(8'h10 + 8'(i));
    put(8'h33);
    put(8'h44);
  endtask

  task automatic sync(input int n);
    for (int i = 0; i < n; i++) put(8'hFF);
  endtask

  task automatic reps(input int n);
    for (int r = 0; r < n; r++)
      for (int k = 0; k < 6; k++) put(oct(k));
  endtask

  task automatic tail();
    for (int i = 0; i < 4; i++) put(8'h5A);
  endtask

  // Sends the frame; checks the pulse one cycle after the last byte and its drop after that.
  task automatic send(input logic good, input logic exp, input string tag);
    for (int i = 0; i < flen; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = fbuf[i];
      rx_sof   = (i == 0);
      rx_eof   = (i == flen - 1);
      rx_good  = good;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_good = 1'b0;
    chk(wake_pulse, exp, tag);
    @(negedge clk);
    chk(wake_pulse, 1'b0, {tag, " R9 single cycle"});
  endtask

  task automatic clear_status();
    @(negedge clk);
    status_clr = 1'b1;
    @(negedge clk);
    status_clr = 1'b0;
    chk(wake_status, 1'b0, "R10 cleared");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(wake_pulse, 1'b0, "R1 pulse in reset");
    rst = 1'b0;
    @(negedge clk);
    chk(wake_pulse, 1'b0, "R1 pulse after reset");
    chk(wake_status, 1'b0, "R1 status after reset");

    // R4 R5 R6 R9: power code x enable x good
    for (int p = 0; p < 4; p++)
      for (int e = 0; e < 2; e++)
        for (int g = 0; g < 2; g++) begin
          logic exp;
          pwr_state = 2'(p);
          mp_enable = 1'(e);
          exp = (g == 1) && ((p == 0 && e == 1) || p == 1);
          head(); sync(6); reps(REPS); tail();
          send(1'(g), exp, $sformatf("R4 R5 R6 R9 pwr=%0d en=%0d good=%0d", p, e, g));
          chk(wake_status, exp, "R10 status follows pulse");
          clear_status();
        end

    pwr_state = 2'b01;
    mp_enable = 1'b0;

    // R7 R11: sync run length
    for (int n = 5; n <= 10; n++) begin
      head(); sync(n); reps(REPS); tail();
      send(1'b1, n >= 6, $sformatf("R7 R11 sync length %0d", n));
    end
    clear_status();

    // R2: byte order reversed within each copy
    head(); sync(6);
    for (int r = 0; r < REPS; r++)
      for (int k = 5; k >= 0; k--) put(oct(k));
    tail();
    send(1'b1, 1'b0, "R2 reversed order");

    // R11: one copy short
    head(); sync(6); reps(REPS - 1); tail();
    send(1'b1, 1'b0, "R11 copies short");

    // R3: sync inside header not examined
    flen = 0; sync(HDR); reps(REPS); tail();
    send(1'b1, 1'b0, "R3 sync in header");
    // R3: pattern starts at first examined byte, ends the frame
    flen = 0;
    for (int i = 0; i < HDR; i++) put(8'h20 + 8'(i));
    sync(6); reps(REPS);
    send(1'b1, 1'b1, "R3 R9 pattern at boundary and on last byte");
    clear_status();

    // R11 R8: corrupt each address position
    for (int pos = 0; pos < REPS * 6; pos++) begin
      head(); sync(6); reps(REPS);
      fbuf[HDR + 2 + 6 + pos] = oct(pos % 6) ^ 8'h01;
      tail();
      send(1'b1, 1'b0, $sformatf("R8 R11 corrupt position %0d", pos));
    end

    // R8: mismatching FF byte starts a new sync run
    head(); sync(6); reps(1); put(oct(0)); put(oct(1));
    put(8'hFF); sync(5); reps(REPS); tail();
    send(1'b1, 1'b1, "R8 mismatch FF reused as sync");
    clear_status();
    head(); sync(6); reps(1); put(oct(0)); put(oct(1));
    put(8'h00); sync(5); reps(REPS); tail();
    send(1'b1, 1'b0, "R8 non-FF mismatch then five FF");

    // R10: set wins over a clear held through the frame
    status_clr = 1'b1;
    head(); sync(6); reps(REPS); tail();
    send(1'b1, 1'b1, "R10 pulse under clear");
    status_clr = 1'b0;
    clear_status();
    head(); sync(6); reps(REPS); tail();
    status_clr = 1'b1;
    @(negedge clk);
    status_clr = 1'b0;
    send(1'b1, 1'b1, "R10 set again");
    chk(wake_status, 1'b1, "R10 sticky after frame");
    repeat (5) @(negedge clk);
    chk(wake_status, 1'b1, "R10 sticky while idle");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule